// File: doc/BRIEF.md
# One-Time-Programmable Protection Register

This block holds the security area of a flash device. It stores a small user segment that can be written only once and a lock word that guards it. A single-cycle program request carries an address and a data word. The request is applied to one segment word or to the lock word, and the block always answers with a completion pulse and an error flag. A combinational read port returns any segment word or the lock word.

Programming follows flash rules: a bit can only go from 1 to 0. Two lock bits form a protection hierarchy. The segment-protect bit freezes the user segment and also freezes the lock word itself. The security-protect bit permanently protects the device's security block and is presented on an output for neighbouring logic. Only a reset returns storage to the erased state; it stands in for non-volatile retention in simulation. Command decoding and program-pulse timing are handled elsewhere.

Top module: `otp_prot_bank`

## Requirements
- R1: After reset every segment word and the lock word read all ones, `done_o` and `err_o` are 0, and both lock outputs are 0.
- R2: Segment words sit at addresses 0 to SEG_WORDS-1. A permitted program to one of them stores old AND data, and the new value is readable from the cycle after the request. No other word changes.
- R3: No stored bit ever returns from 0 to 1. Writing a 1 over a programmed 0 leaves the 0 and is not an error.
- R4: `done_o` is high for exactly the one cycle after each cycle in which `prog_req_i` is high, and is low at all other times.
- R5: The lock word sits at address SEG_WORDS. Once its bit 1 is 0, `seg_locked_o` is high. From then on every segment program raises `err_o` and leaves the segment unchanged.
- R6: Once lock bit 1 is 0, every program to the lock word raises `err_o` and leaves the lock word unchanged, so bit 2 can no longer be cleared.
- R7: Clearing lock bit 2 while bit 1 is still 1 succeeds and sets `sec_locked_o` high permanently. The segment stays programmable.
- R8: Only lock bits 1 and 2 are programmable. All other lock bits always read 1, whatever data is written.
- R9: A program to any address above SEG_WORDS raises `err_o` and changes no storage. A read from such an address returns all ones.
- R10: `err_o` gives the result of the most recent request: 1 on failure, 0 on success. It holds that value until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, restores the erased state |
| prog_req_i | input | 1 | Program request, one operation per high cycle |
| prog_addr_i | input | ADDR_W | Target: segment word index, or SEG_WORDS for the lock word |
| prog_data_i | input | WORD_W | Data; zero bits clear the matching stored bits |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | WORD_W | Read data for `rd_addr_i` |
| done_o | output | 1 | Completion pulse, one cycle after a request |
| err_o | output | 1 | Status error of the last completed request |
| seg_locked_o | output | 1 | User segment is frozen (lock bit 1 cleared) |
| sec_locked_o | output | 1 | Security block is protected (lock bit 2 cleared) |

## Verification
The bench checks that a later write of ones over programmed zeros keeps the zeros; a design that stores data instead of AND-ing it would restore erased bits. After the segment is frozen, it tries to clear lock bit 2. A design that only gates segment writes would then lock the security block, which must not happen. It writes zeros to the unprogrammable lock bits and to addresses past the lock word; a missing mask or bounds check would show up as wrong read-back or a missing error. It also checks that a good request after a failed one clears the error flag, which catches a flag that stays set by mistake.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int unsigned LOCK_SEG_BIT = 1;
  localparam int unsigned LOCK_SEC_BIT = 2;
endpackage

// File: rtl/otp_word.sv
module otp_word #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '1;
    else if (we_i) q_o <= q_o & data_i;
  end
endmodule

// File: rtl/otp_lock_reg.sv
module otp_lock_reg
  import otp_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] q_o,
  output logic              seg_locked_o,
  output logic              sec_locked_o
);
  localparam logic [WORD_W-1:0] PROG_MASK =
    (WORD_W'(1) << LOCK_SEG_BIT) | (WORD_W'(1) << LOCK_SEC_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '1;
    else if (we_i) q_o <= q_o & (data_i | ~PROG_MASK);
  end

  assign seg_locked_o = ~q_o[LOCK_SEG_BIT];
  assign sec_locked_o = ~q_o[LOCK_SEC_BIT];
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl #(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned SEG_WORDS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 seg_locked_i,
  output logic [SEG_WORDS-1:0] seg_we_o,
  output logic                 lock_we_o,
  output logic                 done_o,
  output logic                 err_o
);
  localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(SEG_WORDS);

  logic bad_addr;
  logic allow;

  assign bad_addr  = addr_i > LOCK_ADDR;
  // lock bit 1 freezes both the segment and the lock word
  assign allow     = req_i & ~bad_addr & ~seg_locked_i;
  assign lock_we_o = allow & (addr_i == LOCK_ADDR);

  for (genvar i = 0; i < SEG_WORDS; i++) begin : g_we
    assign seg_we_o[i] = allow & (addr_i == ADDR_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= req_i;
      if (req_i) err_o <= bad_addr | seg_locked_i;
    end
  end
endmodule

// File: rtl/otp_prot_bank.sv
module otp_prot_bank #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned SEG_WORDS = 4,
  parameter int unsigned ADDR_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_req_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [WORD_W-1:0] prog_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              done_o,
  output logic              err_o,
  output logic              seg_locked_o,
  output logic              sec_locked_o
);
  localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(SEG_WORDS);

  logic [SEG_WORDS-1:0]        seg_we;
  logic                        lock_we;
  logic [WORD_W-1:0]           seg_q [SEG_WORDS];
  logic [SEG_WORDS*WORD_W-1:0] seg_flat;
  logic [WORD_W-1:0]           lock_q;

  otp_prog_ctrl #(.ADDR_W(ADDR_W), .SEG_WORDS(SEG_WORDS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (prog_req_i),
    .addr_i      (prog_addr_i),
    .seg_locked_i(seg_locked_o),
    .seg_we_o    (seg_we),
    .lock_we_o   (lock_we),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  for (genvar i = 0; i < SEG_WORDS; i++) begin : g_seg
    otp_word #(.WORD_W(WORD_W)) u_word (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (seg_we[i]),
      .data_i(prog_data_i),
      .q_o   (seg_q[i])
    );
    assign seg_flat[i*WORD_W +: WORD_W] = seg_q[i];
  end

  otp_lock_reg #(.WORD_W(WORD_W)) u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (lock_we),
    .data_i      (prog_data_i),
    .q_o         (lock_q),
    .seg_locked_o(seg_locked_o),
    .sec_locked_o(sec_locked_o)
  );

  always_comb begin
    rd_data_o = '1;
    for (int i = 0; i < SEG_WORDS; i++)
      if (rd_addr_i == ADDR_W'(i)) rd_data_o = seg_q[i];
    if (rd_addr_i == LOCK_ADDR) rd_data_o = lock_q;
  end
endmodule

// File: rtl/otp_prot_bank_chk.sv
module otp_prot_bank_chk #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned SEG_WORDS = 4,
  parameter int unsigned ADDR_W    = 3
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        prog_req_i,
  input logic [ADDR_W-1:0]           prog_addr_i,
  input logic                        done_o,
  input logic                        err_o,
  input logic                        seg_locked_o,
  input logic                        sec_locked_o,
  input logic [SEG_WORDS*WORD_W-1:0] seg_flat,
  input logic [WORD_W-1:0]           lock_q
);
  localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(SEG_WORDS);

  a_r4_done_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_i |=> done_o);
  a_r4_no_stray_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_req_i |=> !done_o);
  a_r3_no_bit_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seg_flat & ~$past(seg_flat)) == '0) && ((lock_q & ~$past(lock_q)) == '0));
  a_r5_seg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_locked_o && prog_req_i && prog_addr_i < LOCK_ADDR) |=> (err_o && $stable(seg_flat)));
  a_r6_lock_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_locked_o && prog_req_i && prog_addr_i == LOCK_ADDR) |=> (err_o && $stable(lock_q)));
  a_r7_sec_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_locked_o |=> sec_locked_o);
  a_r9_bad_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_req_i && prog_addr_i > LOCK_ADDR) |=> (err_o && $stable(seg_flat) && $stable(lock_q)));
  a_r10_ok_clears_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_req_i && !seg_locked_o && prog_addr_i <= LOCK_ADDR) |=> !err_o);
endmodule

bind otp_prot_bank otp_prot_bank_chk #(
  .WORD_W(WORD_W), .SEG_WORDS(SEG_WORDS), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .prog_req_i  (prog_req_i),
  .prog_addr_i (prog_addr_i),
  .done_o      (done_o),
  .err_o       (err_o),
  .seg_locked_o(seg_locked_o),
  .sec_locked_o(sec_locked_o),
  .seg_flat    (seg_flat),
  .lock_q      (lock_q)
);

// File: tb/otp_prot_bank_bench.sv
module otp_prot_bank_bench;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned SEG_WORDS = 4;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] LOCK_A = 3'd4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              prog_req_i = 1'b0;
  logic [ADDR_W-1:0] prog_addr_i = '0;
  logic [WORD_W-1:0] prog_data_i = '0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [WORD_W-1:0] rd_data_o;
  logic done_o, err_o, seg_locked_o, sec_locked_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  otp_prot_bank #(.WORD_W(WORD_W), .SEG_WORDS(SEG_WORDS), .ADDR_W(ADDR_W)) u_otp_prot_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .prog_req_i(prog_req_i), .prog_addr_i(prog_addr_i),
    .prog_data_i(prog_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .done_o(done_o), .err_o(err_o), .seg_locked_o(seg_locked_o), .sec_locked_o(sec_locked_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [WORD_W-1:0] d);
    rd_addr_i = a;
    #1 d = rd_data_o;
  endtask

  task automatic chk_word(input string tag, input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] exp);
    logic [WORD_W-1:0] d;
    rd(a, d);
    chk(tag, 32'(d), 32'(exp));
  endtask

  // request in one cycle, check the completion in the next
  task automatic prog(input string tag, input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d,
                      input logic exp_err);
    @(negedge clk_i);
    prog_req_i = 1'b1; prog_addr_i = a; prog_data_i = d;
    @(negedge clk_i);
    prog_req_i = 1'b0; prog_data_i = '1;
    chk({tag, " R4 done"}, 32'(done_o), 32'd1);
    chk({tag, " err"}, 32'(err_o), 32'(exp_err));
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    for (int i = 0; i <= SEG_WORDS; i++) chk_word("R1 erased", ADDR_W'(i), 16'hFFFF);
    chk("R1 done", 32'(done_o), 0);
    chk("R1 err", 32'(err_o), 0);
    chk("R1 seg_locked", 32'(seg_locked_o), 0);
    chk("R1 sec_locked", 32'(sec_locked_o), 0);
  endtask

  task automatic t_seg_and();
    prog("R2 first", 3'd1, 16'hF0F0, 1'b0);
    chk_word("R2 word1", 3'd1, 16'hF0F0);
    chk_word("R2 word0 untouched", 3'd0, 16'hFFFF);
    chk_word("R2 word3 untouched", 3'd3, 16'hFFFF);
    @(negedge clk_i);
    chk("R4 done low after pulse", 32'(done_o), 0);
    prog("R2 second", 3'd1, 16'h0FFF, 1'b0);
    chk_word("R2 AND result", 3'd1, 16'h00F0);
    prog("R3 ones", 3'd1, 16'hFFFF, 1'b0);
    chk_word("R3 zeros kept", 3'd1, 16'h00F0);
    prog("R3 set attempt", 3'd1, 16'hFF0F, 1'b0);
    chk_word("R3 only clears", 3'd1, 16'h0000);
  endtask

  task automatic t_bad_addr();
    prog("R9 addr5", 3'd5, 16'h0000, 1'b1);
    prog("R9 addr7", 3'd7, 16'h0000, 1'b1);
    chk_word("R9 word0 kept", 3'd0, 16'hFFFF);
    chk_word("R9 word2 kept", 3'd2, 16'hFFFF);
    chk_word("R9 lock kept", LOCK_A, 16'hFFFF);
    chk_word("R9 read out of range", 3'd6, 16'hFFFF);
    repeat (3) @(negedge clk_i);
    chk("R10 err held", 32'(err_o), 1);
    prog("R10 success clears", 3'd3, 16'hFFFE, 1'b0);
    chk_word("R10 word3", 3'd3, 16'hFFFE);
  endtask

  task automatic t_sec_lock();
    prog("R8 fixed bits", LOCK_A, 16'h0003, 1'b0);
    chk_word("R8 lock value", LOCK_A, 16'hFFFB);
    chk("R7 sec_locked", 32'(sec_locked_o), 1);
    chk("R7 seg still open", 32'(seg_locked_o), 0);
    prog("R7 segment programmable", 3'd2, 16'h1234, 1'b0);
    chk_word("R7 word2", 3'd2, 16'h1234);
    repeat (2) @(negedge clk_i);
    chk("R7 sec stays", 32'(sec_locked_o), 1);
  endtask

  task automatic t_seg_lock();
    prog("R5 clear bit1", LOCK_A, 16'hFFFD, 1'b0);
    chk_word("R5 lock value", LOCK_A, 16'hFFFD);
    chk("R5 seg_locked", 32'(seg_locked_o), 1);
    prog("R5 seg write refused", 3'd0, 16'h0000, 1'b1);
    chk_word("R5 word0 kept", 3'd0, 16'hFFFF);
    prog("R5 seg write word3", 3'd3, 16'h00FF, 1'b1);
    chk_word("R5 word3 kept", 3'd3, 16'hFFFF);
    prog("R6 bit2 refused", LOCK_A, 16'hFFFB, 1'b1);
    chk_word("R6 lock kept", LOCK_A, 16'hFFFD);
    chk("R6 sec not locked", 32'(sec_locked_o), 0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_seg_and();
    t_bad_addr();
    t_sec_lock();
    do_reset();
    t_reset();
    t_seg_lock();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule